// File: doc/BRIEF.md
# Set/Way Data-Cache Clean Sequencer

This block cleans and invalidates a whole set-associative data cache by issuing one maintenance operation for each set/way pair. On a start request it decodes the cache geometry from a 32-bit size-identification word. From that word it derives the shift that places the set index and the shift that places the way number in the operand. It then streams the operands out over a valid/ready handshake.

Sets are walked from the highest index down to zero. For each set, every way is walked from the highest number down to zero. When the walk ends without an error, the block can optionally issue one register write to an outer-level cache controller. That write carries a mask selecting every outer way and goes to a fixed offset above the controller's base address. If the cache is reported as disabled when start is accepted, the block finishes at once and does nothing.

Top module: `sw_clean_seq`

## Requirements
- R1: The size word is decoded as follows. Bits [2:0] hold the line-size code, bits [12:3] hold the way count minus one, and bits [27:13] hold the set count minus one. Bits [31:28] are ignored. All inputs are captured when start is accepted and are not sampled again until the next start.
- R2: Each operand equals (set << (code + 4)) OR (way << (32 - B)), where B is the number of bits needed to write the way count minus one, so that 2^B is at least the way count.
- R3: Operations are issued in this order: sets from the maximum down to 0 in the outer loop, and ways from the maximum down to 0 in the inner loop. This gives exactly sets × ways operations.
- R4: While op_valid is high and op_ready is low, op_valid stays high and op_data holds its value.
- R5: If cache_on is low when start is accepted, done pulses on the next cycle with error low, and no operation or register write is issued.
- R6: When the last operation has been accepted without error, reg_wr_valid is high for one cycle. In that cycle reg_wr_addr is outer_base + 0x7FC and reg_wr_data is (1 << outer_ways) - 1. done follows in the next cycle with error low.
- R7: If op_err is high when an operation is accepted, no further operation or register write follows, and done and error are both high on the next cycle.
- R8: With a single-way cache (way field 0), the way number adds no bits to the operand, which becomes set << (code + 4).
- R9: A start request while a sequence is running has no effect on the operations, the register write or the completion.
- R10: After reset, op_valid, reg_wr_valid, done and error are all low.
- R11: done is a single-cycle pulse, and error is high only together with done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a full clean sequence |
| cache_on | input | 1 | Data cache enabled at the time of the request |
| size_id | input | 32 | Cache geometry word |
| outer_ways | input | 5 | Number of ways in the outer cache |
| outer_base | input | 32 | Base address of the outer cache controller |
| op_valid | output | 1 | Maintenance operation valid |
| op_data | output | 32 | Encoded set/way operand |
| op_ready | input | 1 | Operation accepted |
| op_err | input | 1 | Accepted operation failed (qualified by op_ready) |
| reg_wr_valid | output | 1 | Outer controller register write strobe |
| reg_wr_addr | output | 32 | Outer controller register address |
| reg_wr_data | output | 32 | Outer way mask |
| done | output | 1 | Sequence finished (one-cycle pulse) |
| error | output | 1 | Sequence ended on an operation error |

## Verification
The assertions assume the following about the inputs. op_err matters only in a cycle where op_ready is high. The geometry fits the operand width, meaning the set index shifted by at most 11 does not reach past bit 31. The bench drives op_err only together with op_ready, and it uses small geometries with line codes from 0 to 3. It changes size_id and cache_on after start, and during a walk it raises start with different inputs, which exercises input capture and the rule that a busy sequencer ignores start. op_ready follows either a steady-high pattern or a random pattern, so the hold rule is exercised across stalls of varying length.

// File: rtl/sw_clean_pkg.sv
package sw_clean_pkg;
   // Field layout of the geometry word (bit positions are behaviour)
   localparam int LSZ_LSB  = 0;
   localparam int LSZ_W    = 3;
   localparam int WAY_LSB  = 3;
   localparam int WAY_W    = 10;
   localparam int SET_LSB  = 13;
   localparam int SET_W    = 15;
   localparam int LINE_BIAS = 4;
   localparam int SSH_W    = 4;
   localparam int WAYB_W   = $clog2(WAY_W + 1);

   typedef struct packed {
      logic [SET_W-1:0]  sets_m1;
      logic [WAY_W-1:0]  ways_m1;
      logic [SSH_W-1:0]  set_sh;
      logic [WAYB_W-1:0] way_bits;
   } geom_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_WALK,
      ST_OUTER,
      ST_FIN
   } seq_state_e;
endpackage

// File: rtl/sw_geom_decode.sv
module sw_geom_decode
   import sw_clean_pkg::*;
#(
   parameter int ID_W = 32
) (
   input  logic [ID_W-1:0] size_id,
   output geom_t           geom
);
   localparam int USED_W = SET_LSB + SET_W;

   generate
      if (ID_W < USED_W) begin : g_bad_id_w
         $error("sw_geom_decode: ID_W too narrow for geometry fields");
      end
      if (ID_W > USED_W) begin : g_spare
         logic unused_hi;
         assign unused_hi = ^size_id[ID_W-1:USED_W];
      end
   endgenerate

   logic [LSZ_W-1:0]  code;
   logic [WAYB_W-1:0] wb;

   assign code          = size_id[LSZ_LSB +: LSZ_W];
   assign geom.sets_m1  = size_id[SET_LSB +: SET_W];
   assign geom.ways_m1  = size_id[WAY_LSB +: WAY_W];
   assign geom.set_sh   = SSH_W'(code) + SSH_W'(LINE_BIAS);

   // bits needed to hold ways-1, i.e. ceil(log2(ways))
   always_comb begin
      wb = '0;
      for (int i = 0; i < WAY_W; i++) begin
         if (geom.ways_m1[i]) wb = WAYB_W'(i + 1);
      end
   end
   assign geom.way_bits = wb;
endmodule

// File: rtl/sw_set_way_walk.sv
module sw_set_way_walk #(
   parameter int SET_W = 15,
   parameter int WAY_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [SET_W-1:0] ld_sets_m1,
   input  logic [WAY_W-1:0] ld_ways_m1,
   input  logic [WAY_W-1:0] rl_ways_m1,
   input  logic             step,
   output logic [SET_W-1:0] cur_set,
   output logic [WAY_W-1:0] cur_way,
   output logic             last
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_set <= '0;
         cur_way <= '0;
      end else if (load) begin
         cur_set <= ld_sets_m1;
         cur_way <= ld_ways_m1;
      end else if (step) begin
         if (cur_way == '0) begin
            cur_set <= cur_set - 1'b1;
            cur_way <= rl_ways_m1;
         end else begin
            cur_way <= cur_way - 1'b1;
         end
      end
   end

   assign last = (cur_set == '0) && (cur_way == '0);

   // R3
   way_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && cur_way != '0) |=> (cur_way == $past(cur_way) - 1'b1) && $stable(cur_set));

   // R3
   set_desc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && cur_way == '0 && !last) |=> (cur_set == $past(cur_set) - 1'b1) && (cur_way == $past(rl_ways_m1)));
endmodule

// File: rtl/sw_operand_pack.sv
module sw_operand_pack
   import sw_clean_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [SET_W-1:0]  set_idx,
   input  logic [WAY_W-1:0]  way_idx,
   input  logic [SSH_W-1:0]  set_sh,
   input  logic [WAYB_W-1:0] way_bits,
   output logic [DATA_W-1:0] operand
);
   localparam int MAX_SET_SH = (1 << LSZ_W) - 1 + LINE_BIAS;

   generate
      if (DATA_W < SET_W + MAX_SET_SH) begin : g_bad_data_w
         $error("sw_operand_pack: DATA_W cannot hold shifted set index");
      end
   endgenerate

   logic [DATA_W-1:0] set_part;
   logic [DATA_W-1:0] way_part;

   assign set_part = DATA_W'(set_idx) << set_sh;

   always_comb begin
      if (way_bits == '0) way_part = '0;
      else                way_part = DATA_W'(way_idx) << (DATA_W - int'(way_bits));
   end

   assign operand = set_part | way_part;
endmodule

// File: rtl/sw_clean_seq.sv
module sw_clean_seq
   import sw_clean_pkg::*;
#(
   parameter int                DATA_W   = 32,
   parameter int                ADDR_W   = 32,
   parameter int                OW_W     = 5,
   parameter bit                OUTER_EN = 1'b1,
   parameter logic [ADDR_W-1:0] MASK_OFS = 'h7FC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              cache_on,
   input  logic [31:0]       size_id,
   input  logic [OW_W-1:0]   outer_ways,
   input  logic [ADDR_W-1:0] outer_base,
   output logic              op_valid,
   output logic [DATA_W-1:0] op_data,
   input  logic              op_ready,
   input  logic              op_err,
   output logic              reg_wr_valid,
   output logic [ADDR_W-1:0] reg_wr_addr,
   output logic [DATA_W-1:0] reg_wr_data,
   output logic              done,
   output logic              error
);
   generate
      if (OW_W > $clog2(DATA_W) + 1) begin : g_bad_ow_w
         $error("sw_clean_seq: OW_W wider than needed for DATA_W mask");
      end
   endgenerate

   seq_state_e        st;
   geom_t             geom_in;
   geom_t             geom_q;
   logic [OW_W-1:0]   ow_q;
   logic [ADDR_W-1:0] base_q;
   logic              err_q;
   logic              accept;
   logic              xfer;
   logic              step;
   logic              last;
   logic [SET_W-1:0]  cur_set;
   logic [WAY_W-1:0]  cur_way;

   assign accept = (st == ST_IDLE) && start;
   assign xfer   = (st == ST_WALK) && op_ready;
   assign step   = xfer && !op_err;

   sw_geom_decode #(.ID_W(32)) u_dec (
      .size_id (size_id),
      .geom    (geom_in)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         geom_q <= '0;
         ow_q   <= '0;
         base_q <= '0;
         err_q  <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (start) begin
               geom_q <= geom_in;
               ow_q   <= outer_ways;
               base_q <= outer_base;
               err_q  <= 1'b0;
               st     <= cache_on ? ST_WALK : ST_FIN;
            end
            ST_WALK: if (xfer) begin
               if (op_err) begin
                  err_q <= 1'b1;
                  st    <= ST_FIN;
               end else if (last) begin
                  st    <= OUTER_EN ? ST_OUTER : ST_FIN;
               end
            end
            ST_OUTER: st <= ST_FIN;
            default:  st <= ST_IDLE;
         endcase
      end
   end

   sw_set_way_walk #(.SET_W(SET_W), .WAY_W(WAY_W)) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .ld_sets_m1 (geom_in.sets_m1),
      .ld_ways_m1 (geom_in.ways_m1),
      .rl_ways_m1 (geom_q.ways_m1),
      .step       (step),
      .cur_set    (cur_set),
      .cur_way    (cur_way),
      .last       (last)
   );

   sw_operand_pack #(.DATA_W(DATA_W)) u_pack (
      .set_idx  (cur_set),
      .way_idx  (cur_way),
      .set_sh   (geom_q.set_sh),
      .way_bits (geom_q.way_bits),
      .operand  (op_data)
   );

   assign op_valid = (st == ST_WALK);
   assign done     = (st == ST_FIN);
   assign error    = done && err_q;

   generate
      if (OUTER_EN) begin : g_outer
         assign reg_wr_valid = (st == ST_OUTER);
         assign reg_wr_addr  = base_q + MASK_OFS;
         assign reg_wr_data  = (DATA_W'(1) << ow_q) - DATA_W'(1);
      end else begin : g_no_outer
         logic unused_outer;
         assign unused_outer = ^{ow_q, base_q};
         assign reg_wr_valid = 1'b0;
         assign reg_wr_addr  = '0;
         assign reg_wr_data  = '0;
      end
   endgenerate

   // R4
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !op_ready) |=> (op_valid && $stable(op_data)));

   // R7
   err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_ready && op_err) |=> (done && error && !op_valid && !reg_wr_valid));

   // R6
   outer_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_valid |=> (done && !error));

   // R5
   off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && start && !cache_on) |=> (done && !error && !op_valid));

   // R11
   err_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> done);

   // R11
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/test_sw_clean_seq.sv
module test_sw_clean_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        cache_on = 1'b0;
   logic [31:0] size_id = '0;
   logic [4:0]  outer_ways = '0;
   logic [31:0] outer_base = '0;
   logic        op_valid;
   logic [31:0] op_data;
   logic        op_ready = 1'b0;
   logic        op_err = 1'b0;
   logic        reg_wr_valid;
   logic [31:0] reg_wr_addr;
   logic [31:0] reg_wr_data;
   logic        done;
   logic        error;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sw_clean_seq i_sw_clean_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cache_on(cache_on),
      .size_id(size_id), .outer_ways(outer_ways), .outer_base(outer_base),
      .op_valid(op_valid), .op_data(op_data), .op_ready(op_ready), .op_err(op_err),
      .reg_wr_valid(reg_wr_valid), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .done(done), .error(error)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_quiet(input string req);
      chk(!op_valid, req, "op_valid idle", 32'(op_valid), 0);
      chk(!reg_wr_valid, req, "reg_wr_valid idle", 32'(reg_wr_valid), 0);
      chk(!done, req, "done idle", 32'(done), 0);
      chk(!error, req, "error idle", 32'(error), 0);
   endtask

   // Reference model: builds the expected operand list from R1/R2/R3 and
   // walks it cycle by cycle against the design's ports.
   task automatic run_seq(input int sets_m1, input int ways_m1, input int code,
                          input int ow, input logic [31:0] base, input bit on,
                          input int err_at, input int poke_at, input bit rnd);
      logic [31:0] q[$];
      int sh;
      int wb;
      int idx;
      bit stop;
      bit r;
      sh = code + 4;
      wb = 0;
      while ((1 << wb) < ways_m1 + 1) wb++;
      for (int s = sets_m1; s >= 0; s--) begin
         for (int w = ways_m1; w >= 0; w--) begin
            longint v;
            v = longint'(s) << sh;
            if (wb != 0) v = v | (longint'(w) << (32 - wb));
            q.push_back(v[31:0]);
         end
      end
      @(negedge clk);
      start      = 1'b1;
      cache_on   = on;
      size_id    = 32'hA000_0000 | (sets_m1 << 13) | (ways_m1 << 3) | code;
      outer_ways = 5'(ow);
      outer_base = base;
      @(negedge clk);
      start      = 1'b0;
      size_id    = 32'h0FFF_FFFF;   // R1: captured value must be used
      cache_on   = ~on;
      outer_ways = 5'd3;
      outer_base = 32'h5555_0000;
      if (!on) begin
         // R5
         chk(done, "R5", "done after disabled start", 32'(done), 1);
         chk(!error, "R5", "error after disabled start", 32'(error), 0);
         chk(!op_valid, "R5", "no op when disabled", 32'(op_valid), 0);
         chk(!reg_wr_valid, "R5", "no reg write when disabled", 32'(reg_wr_valid), 0);
      end else begin
         idx  = 0;
         stop = 1'b0;
         while (!stop && idx < q.size()) begin
            chk(op_valid, "R3", "op_valid in walk", 32'(op_valid), 1);
            chk(op_data == q[idx], "R2", $sformatf("operand %0d", idx), op_data, q[idx]);
            chk(!done && !reg_wr_valid, "R11", "no done during walk",
                32'({done, reg_wr_valid}), 0);
            r = rnd ? 1'($urandom_range(0, 1)) : 1'b1;
            op_ready = r;
            op_err   = r && (idx == err_at);
            if (idx == poke_at) begin
               // R9: a start request while busy
               start      = 1'b1;
               cache_on   = 1'b0;
               size_id    = 32'h0000_2008;
               outer_ways = 5'd1;
            end
            @(negedge clk);
            op_ready = 1'b0;
            op_err   = 1'b0;
            start    = 1'b0;
            if (r) begin
               if (idx == err_at) stop = 1'b1;
               idx++;
            end
         end
         if (stop) begin
            // R7
            chk(done && error, "R7", "done+error after op error", 32'({done, error}), 3);
            chk(!op_valid, "R7", "no op after error", 32'(op_valid), 0);
            chk(!reg_wr_valid, "R7", "no reg write after error", 32'(reg_wr_valid), 0);
         end else begin
            // R6
            chk(reg_wr_valid, "R6", "reg write strobe", 32'(reg_wr_valid), 1);
            chk(reg_wr_addr == base + 32'h7FC, "R6", "reg write addr", reg_wr_addr, base + 32'h7FC);
            chk(reg_wr_data == ((32'd1 << ow) - 32'd1), "R6", "reg write mask",
                reg_wr_data, (32'd1 << ow) - 32'd1);
            chk(!done && !op_valid, "R6", "no done with reg write", 32'({done, op_valid}), 0);
            @(negedge clk);
            chk(done && !error, "R6", "done after reg write", 32'({done, error}), 2);
            chk(!reg_wr_valid, "R6", "single reg write", 32'(reg_wr_valid), 0);
         end
      end
      @(negedge clk);
      chk_quiet("R11");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10
      chk_quiet("R10");
      rst_n = 1'b1;
      @(negedge clk);
      chk_quiet("R10");

      // R1 R2 R3 R6: 4 sets, 4 ways, code 1, steady ready
      run_seq(3, 3, 1, 8, 32'h1000_0000, 1'b1, -1, -1, 1'b0);
      // R4: random stalls, 8 sets, 2 ways, code 3, 16 outer ways
      run_seq(7, 1, 3, 16, 32'h2000_0800, 1'b1, -1, -1, 1'b1);
      // R8: single way
      run_seq(3, 0, 0, 4, 32'h0000_F000, 1'b1, -1, -1, 1'b0);
      // R2: non-power-of-two way count (3 ways)
      run_seq(2, 2, 2, 1, 32'h3000_0000, 1'b1, -1, -1, 1'b1);
      // R5: cache disabled
      run_seq(3, 3, 1, 8, 32'h1000_0000, 1'b0, -1, -1, 1'b0);
      // R7: error mid-walk
      run_seq(3, 3, 1, 8, 32'h1000_0000, 1'b1, 5, -1, 1'b1);
      // R7: error on the last operation suppresses the outer write
      run_seq(1, 1, 0, 8, 32'h1000_0000, 1'b1, 3, -1, 1'b0);
      // R9: start while busy is ignored
      run_seq(3, 1, 1, 2, 32'h4000_0000, 1'b1, -1, 2, 1'b1);
      // R6: zero outer ways gives an empty mask
      run_seq(0, 3, 0, 0, 32'h0000_0000, 1'b1, -1, -1, 1'b0);

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule